// File: doc/BRIEF.md
# Three-Channel Prescaled Interval Timer

This peripheral holds three independent 16-bit up-counters that share one input clock. Each channel has its own divider, configuration and status. The interrupt output of a channel rises when an enabled event is pending.

Each channel works in one of two modes. In free mode the counter wraps from 0xFFFF to 0 and records an overflow event. In interval mode the counter climbs to a programmed limit, returns to zero and records an interval event.

Software reaches the registers over a simple synchronous port. The port has 32-bit data and a word address. A write takes effect on the clock edge where `bus_wr` is high. A read returns its data on `bus_rdata` after the edge where `bus_rd` is high. Reading a status register clears the status bits that were read.

Each channel is controlled by a four-state machine. The states are encoded as {interval-mode, stop}:

| State | Encoding | Meaning |
|---|---|---|
| `ST_RUN_FREE` | 00 | counting, free mode |
| `ST_HALT_FREE` | 01 | stopped, free mode |
| `ST_RUN_INTV` | 10 | counting, interval mode |
| `ST_HALT_INTV` | 11 | stopped, interval mode |

The state machine has these transitions:
- **Write transition:** a write to the channel's counter control register moves the machine to the state given by data bits 1 and 0. This transition can lead from any state to any state, including the same state.
- **Hold:** with no counter control write, the machine keeps its state.
- **Reset:** reset places every channel in `ST_HALT_FREE`.

Top module: `tri_interval_timer`

## Requirements
- R1: After reset, counter control reads 0x1 (stopped, free mode) and every other register reads 0. All `irq` bits are low.
- R2: The register map, with n the channel number, uses these word addresses:

  | Register | Word address | Bits that read back |
  |---|---|---|
  | clock control | 0+n | [4:0] |
  | counter control | 3+n | 0, 1 and 5 |
  | count value | 6+n | 16 bits |
  | interval | 9+n | 16 bits |
  | status | 21+n | 0 and 3 |
  | enable | 24+n | 0 and 3 |

  Every other bit reads 0, and any other address reads 0. Writes to the count value are ignored. Counter control bit 5 is stored only.
- R3: Counter control bit 0 = 1 stops the counter. The count then holds its value.
- R4: Writing counter control with bit 4 = 1 clears the count and the divider. Bit 4 always reads 0. With bit 0 = 0 and the divider off, the count equals k after k further clock edges.
- R5: In free mode, a count of 0xFFFF advances to 0 and sets status bit 3.
- R6: In interval mode with limit N, the count runs 0..N and then returns to 0. Status bit 0 is set on the edge of that return. With N = 0, the count stays at 0 and bit 0 is set on every tick.
- R7: Clock control bit 0 enables the divider. Bits [4:1] hold P, and the counter then advances once every 2^(P+1) clocks. With bit 0 = 0, the counter advances on every clock.
- R8: A status read returns the pending bits and clears them. An event that happens on the same edge as the read stays set.
- R9: `irq[n]` is high exactly when a status bit of channel n is set and its matching enable bit (bit 0 or bit 3) is set. With enable at 0, `irq[n]` stays low.
- R10: The channels are independent. Control writes and status reads on one channel do not change another channel.
- R11: `bus_rdata` changes only after a clock edge where `bus_rd` is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | shared clock |
| rst_n | input | 1 | active-low synchronous reset |
| bus_wr | input | 1 | write strobe |
| bus_rd | input | 1 | read strobe |
| bus_addr | input | 6 | word address |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | registered read data |
| irq | output | 3 | per-channel interrupt |

## Verification
**Free mode and stop.** Free counting is sampled after a known number of idle cycles following a restart, which separates an off-by-one restart from a correct one. A stop written mid-count must freeze the value that includes the tick on the stop edge.

**Divider settings.** Three divider settings (ratio 4, ratio 8, and disabled with a nonzero exponent) give counts that differ for each wrong ratio.

**Interval mode.** Interval runs with limits 5 and 0 separate a compare against the limit from a compare against the limit plus one. The limit-0 case also puts an event on the same edge as a status read, which tells read-clear priority from event priority.

**Full wrap.** A full 65536-cycle wrap checks the overflow flag apart from the interval flag.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    // channel state: {interval_mode, stop}
    typedef enum logic [1:0] {
        ST_RUN_FREE  = 2'b00,
        ST_HALT_FREE = 2'b01,
        ST_RUN_INTV  = 2'b10,
        ST_HALT_INTV = 2'b11
    } ch_state_e;

    // word base of each register group
    localparam int GRP_CLK  = 0;
    localparam int GRP_CTL  = 3;
    localparam int GRP_CNT  = 6;
    localparam int GRP_INTV = 9;
    localparam int GRP_STS  = 21;
    localparam int GRP_IER  = 24;

    // field positions
    localparam int CLK_PEN   = 0;
    localparam int CTL_STOP  = 0;
    localparam int CTL_INTV  = 1;
    localparam int CTL_RST   = 4;
    localparam int CTL_SPARE = 5;
    localparam int STS_INTV  = 0;
    localparam int STS_OVF   = 3;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             en,
    input  logic [EXP_W-1:0] exp_sel,
    output logic             tick
);
    localparam int DIV_W = 2 ** EXP_W;
    localparam int SH_W  = EXP_W + 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;
    logic [SH_W-1:0]  shamt;

    always_comb begin
        shamt = SH_W'(exp_sel) + SH_W'(1);
        mask  = (DIV_W'(1) << shamt) - DIV_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     div_q <= '0;
        else if (clear) div_q <= '0;
        else            div_q <= div_q + DIV_W'(1);
    end

    assign tick = !en || ((div_q & mask) == mask);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int EXP_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_wr,
    input  logic              ctl_wr,
    input  logic              intv_wr,
    input  logic              ier_wr,
    input  logic              sts_rd,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] clk_rv,
    output logic [DATA_W-1:0] ctl_rv,
    output logic [DATA_W-1:0] cnt_rv,
    output logic [DATA_W-1:0] intv_rv,
    output logic [DATA_W-1:0] sts_rv,
    output logic [DATA_W-1:0] ier_rv,
    output logic              irq
);
    ch_state_e        state_q, state_d;
    logic             pen_q, spare_q;
    logic [EXP_W-1:0] exp_q;
    logic [CNT_W-1:0] cnt_q, intv_q;
    logic             en_intv_q, en_ovf_q;
    logic             sts_intv_q, sts_ovf_q;
    logic             running, intv_mode;
    logic             tick, restart, step, ev_intv, ev_ovf;
    logic             unused_wdata;

    assign unused_wdata = ^wdata;
    assign restart      = ctl_wr && wdata[CTL_RST];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HALT_FREE;
        else        state_q <= state_d;
    end

    // next state: a control write selects the state from bits {1,0}
    always_comb begin
        state_d = state_q;
        if (ctl_wr) begin
            unique case ({wdata[CTL_INTV], wdata[CTL_STOP]})
                2'b00: state_d = ST_RUN_FREE;
                2'b01: state_d = ST_HALT_FREE;
                2'b10: state_d = ST_RUN_INTV;
                2'b11: state_d = ST_HALT_INTV;
            endcase
        end
    end

    // state outputs
    always_comb begin
        running   = 1'b0;
        intv_mode = 1'b0;
        unique case (state_q)
            ST_RUN_FREE:  running = 1'b1;
            ST_HALT_FREE: running = 1'b0;
            ST_RUN_INTV:  begin running = 1'b1; intv_mode = 1'b1; end
            ST_HALT_INTV: intv_mode = 1'b1;
        endcase
    end

    // configuration storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pen_q     <= 1'b0;
            exp_q     <= '0;
            spare_q   <= 1'b0;
            intv_q    <= '0;
            en_intv_q <= 1'b0;
            en_ovf_q  <= 1'b0;
        end else begin
            if (clk_wr) begin
                pen_q <= wdata[CLK_PEN];
                exp_q <= wdata[EXP_W:1];
            end
            if (ctl_wr)  spare_q <= wdata[CTL_SPARE];
            if (intv_wr) intv_q  <= wdata[CNT_W-1:0];
            if (ier_wr) begin
                en_intv_q <= wdata[STS_INTV];
                en_ovf_q  <= wdata[STS_OVF];
            end
        end
    end

    tmr_prescaler #(.EXP_W(EXP_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (restart),
        .en      (pen_q),
        .exp_sel (exp_q),
        .tick    (tick)
    );

    assign step    = running && tick && !restart;
    assign ev_intv = step && intv_mode && (cnt_q == intv_q);
    assign ev_ovf  = step && !intv_mode && (&cnt_q);

    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (restart) cnt_q <= '0;
        else if (ev_intv) cnt_q <= '0;
        else if (step)    cnt_q <= cnt_q + CNT_W'(1);
    end

    // status: a read clears, but an event on the same edge wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_intv_q <= 1'b0;
            sts_ovf_q  <= 1'b0;
        end else if (sts_rd) begin
            sts_intv_q <= ev_intv;
            sts_ovf_q  <= ev_ovf;
        end else begin
            sts_intv_q <= sts_intv_q | ev_intv;
            sts_ovf_q  <= sts_ovf_q | ev_ovf;
        end
    end

    assign irq = (sts_intv_q && en_intv_q) || (sts_ovf_q && en_ovf_q);

    always_comb begin
        clk_rv             = '0;
        clk_rv[CLK_PEN]    = pen_q;
        clk_rv[EXP_W:1]    = exp_q;
        ctl_rv             = '0;
        ctl_rv[CTL_STOP]   = !running;
        ctl_rv[CTL_INTV]   = intv_mode;
        ctl_rv[CTL_SPARE]  = spare_q;
        cnt_rv             = DATA_W'(cnt_q);
        intv_rv            = DATA_W'(intv_q);
        sts_rv             = '0;
        sts_rv[STS_INTV]   = sts_intv_q;
        sts_rv[STS_OVF]    = sts_ovf_q;
        ier_rv             = '0;
        ier_rv[STS_INTV]   = en_intv_q;
        ier_rv[STS_OVF]    = en_ovf_q;
    end

    // R3: a stopped counter holds
    assert_halt_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !restart) |=> $stable(cnt_q));

    // R4: the restart bit zeroes the count
    assert_restart_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));

    // R5: free wrap flags overflow
    assert_free_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN_FREE && tick && (&cnt_q) && !ctl_wr)
        |=> (cnt_q == '0 && sts_ovf_q));

    // R6: reaching the limit returns to zero and flags the interval event
    assert_intv_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN_INTV && tick && cnt_q == intv_q && !ctl_wr)
        |=> (cnt_q == '0 && sts_intv_q));

    // R8: a read with no new event leaves status clear
    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_rd && !ev_intv && !ev_ovf) |=> (!sts_intv_q && !sts_ovf_q));
endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 16,
    parameter int EXP_W  = 4,
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    logic [NUM_CH-1:0][DATA_W-1:0] clk_rv, ctl_rv, cnt_rv, intv_rv, sts_rv, ier_rv;
    logic [NUM_CH-1:0] wr_clk, wr_ctl, wr_intv, wr_ier, rd_sts;
    logic [DATA_W-1:0] rd_val;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign wr_clk[g]  = bus_wr && (bus_addr == ADDR_W'(GRP_CLK + g));
        assign wr_ctl[g]  = bus_wr && (bus_addr == ADDR_W'(GRP_CTL + g));
        assign wr_intv[g] = bus_wr && (bus_addr == ADDR_W'(GRP_INTV + g));
        assign wr_ier[g]  = bus_wr && (bus_addr == ADDR_W'(GRP_IER + g));
        assign rd_sts[g]  = bus_rd && (bus_addr == ADDR_W'(GRP_STS + g));

        tmr_channel #(.CNT_W(CNT_W), .EXP_W(EXP_W), .DATA_W(DATA_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .clk_wr  (wr_clk[g]),
            .ctl_wr  (wr_ctl[g]),
            .intv_wr (wr_intv[g]),
            .ier_wr  (wr_ier[g]),
            .sts_rd  (rd_sts[g]),
            .wdata   (bus_wdata),
            .clk_rv  (clk_rv[g]),
            .ctl_rv  (ctl_rv[g]),
            .cnt_rv  (cnt_rv[g]),
            .intv_rv (intv_rv[g]),
            .sts_rv  (sts_rv[g]),
            .ier_rv  (ier_rv[g]),
            .irq     (irq[g])
        );
    end

    always_comb begin
        rd_val = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (bus_addr == ADDR_W'(GRP_CLK + c))  rd_val = clk_rv[c];
            if (bus_addr == ADDR_W'(GRP_CTL + c))  rd_val = ctl_rv[c];
            if (bus_addr == ADDR_W'(GRP_CNT + c))  rd_val = cnt_rv[c];
            if (bus_addr == ADDR_W'(GRP_INTV + c)) rd_val = intv_rv[c];
            if (bus_addr == ADDR_W'(GRP_STS + c))  rd_val = sts_rv[c];
            if (bus_addr == ADDR_W'(GRP_IER + c))  rd_val = ier_rv[c];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
    end

    // R11: read data holds between reads
    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/tb_tri_interval_timer.sv
`timescale 1ns/1ps
module tb_tri_interval_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    tri_interval_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // all tasks start and end just after a falling edge
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(6'd3, d);  check("R1 ctl0 reset", d, 32'h1);
        rd(6'd1, d);  check("R1 clk1 reset", d, 32'h0);
        rd(6'd8, d);  check("R1 cnt2 reset", d, 32'h0);
        rd(6'd21, d); check("R1 sts0 reset", d, 32'h0);
        check("R1 irq reset", {29'd0, irq}, 32'h0);
    endtask

    task automatic t_regmap;
        logic [31:0] d;
        wr(6'd2, 32'hFFFF_FFFF);  rd(6'd2, d);  check("R2 clk2 bits", d, 32'h1F);
        wr(6'd5, 32'hFFFF_FFFF);  rd(6'd5, d);  check("R2 ctl2 bits", d, 32'h23);
        wr(6'd26, 32'hFFFF_FFFF); rd(6'd26, d); check("R2 ier2 bits", d, 32'h9);
        wr(6'd8, 32'h1234);       rd(6'd8, d);  check("R2 cnt2 write ignored", d, 32'h0);
        rd(6'd15, d);                           check("R2 unmapped", d, 32'h0);
        wr(6'd11, 32'hFFFF_FFFF); rd(6'd11, d); check("R2 intv2 bits", d, 32'hFFFF);
        idle(3);
        check("R11 rdata holds", bus_rdata, 32'hFFFF);
    endtask

    task automatic t_free_stop;
        logic [31:0] d;
        wr(6'd0, 32'h0);
        wr(6'd3, 32'h10);
        idle(5);
        rd(6'd6, d); check("R4 count after restart", d, 32'd5);
        wr(6'd3, 32'h01);
        idle(4);
        rd(6'd6, d); check("R3 stopped count", d, 32'd7);
        rd(6'd3, d); check("R4 reset bit reads 0", d, 32'h1);
    endtask

    task automatic t_prescale;
        logic [31:0] d;
        wr(6'd1, 32'h3);   wr(6'd4, 32'h10); idle(13);
        rd(6'd7, d); check("R7 ratio 4", d, 32'd3);
        wr(6'd1, 32'h5);   wr(6'd4, 32'h10); idle(17);
        rd(6'd7, d); check("R7 ratio 8", d, 32'd2);
        wr(6'd1, 32'h0A);  wr(6'd4, 32'h10); idle(9);
        rd(6'd7, d); check("R7 divider off", d, 32'd9);
    endtask

    task automatic t_interval;
        logic [31:0] d;
        wr(6'd24, 32'h1);
        wr(6'd9, 32'd5);
        wr(6'd3, 32'h12);
        idle(6);
        check("R9 irq on interval", {31'd0, irq[0]}, 32'h1);
        rd(6'd21, d); check("R6 interval flag", d, 32'h1);
        rd(6'd21, d); check("R8 cleared by read", d, 32'h0);
        check("R9 irq drops", {31'd0, irq[0]}, 32'h0);
        rd(6'd6, d);  check("R6 count wraps at limit", d, 32'd2);
        wr(6'd24, 32'h0);
        idle(3);
        check("R9 irq masked", {31'd0, irq[0]}, 32'h0);
        rd(6'd21, d); check("R9 status still recorded", d, 32'h1);
    endtask

    task automatic t_zero_limit;
        logic [31:0] d;
        wr(6'd1, 32'h0);
        wr(6'd10, 32'h0);
        wr(6'd4, 32'h12);
        idle(2);
        rd(6'd7, d);  check("R6 zero limit holds 0", d, 32'd0);
        rd(6'd22, d); check("R6 zero limit event", d, 32'h1);
        rd(6'd22, d); check("R8 same-edge event kept", d, 32'h1);
    endtask

    task automatic t_overflow;
        logic [31:0] d;
        wr(6'd2, 32'h0);
        wr(6'd26, 32'h8);
        wr(6'd5, 32'h10);
        idle(65536);
        check("R5 irq on overflow", {31'd0, irq[2]}, 32'h1);
        rd(6'd23, d); check("R5 overflow flag only", d, 32'h8);
        rd(6'd8, d);  check("R5 count wrapped", d, 32'd1);
    endtask

    task automatic t_indep;
        logic [31:0] d;
        wr(6'd4, 32'h11);
        idle(5);
        rd(6'd7, d);  check("R10 ch1 stopped at 0", d, 32'd0);
        rd(6'd21, d);
        rd(6'd22, d); check("R10 ch1 status untouched", d, 32'h1);
        check("R10 ch1 irq off", {31'd0, irq[1]}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_free_stop();
        t_prescale();
        t_interval();
        t_zero_limit();
        t_overflow();
        t_indep();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule